// File: doc/BRIEF.md
# Three-State Mealy Traffic Controller

This block is a small synchronous state machine that sequences a traffic signal between two lamp phases. A single-bit request input can interrupt the sequence at any time. The machine holds one of three states in a 2-bit binary register, and the state changes only on the rising clock edge. The 2-bit lamp output is a combinational function of the registered state and the request bit seen in the current cycle, which makes the block a Mealy machine.

With no request pending, the machine alternates between its base state and its alternate state, and it drives a different lamp code in each. A request drives the lamps dark and moves the machine into its request state. The machine leaves the request state once the request drops. The current state code is also brought out on a port, so that each transition can be observed directly.

Top module: `traffic_mealy_ctrl`

## Requirements
- R1: A clock edge taken with `rst_i` high leaves `state_o` at 2'd0 (base state) after that edge.
- R2: In state 2'd0 with `req_i` low, `lamp_o` is 2'b10, and the next state is 2'd1.
- R3: In state 2'd1 with `req_i` low, `lamp_o` is 2'b01, and the next state is 2'd0.
- R4: In state 2'd2 with `req_i` low, `lamp_o` is 2'b01, and the next state is 2'd0.
- R5: In any state with `req_i` high, `lamp_o` is 2'b00, and the next state is 2'd2.
- R6: `lamp_o` follows a change of `req_i` within the same cycle, without waiting for a clock edge, while `state_o` stays unchanged.
- R7: `state_o` only ever shows the codes 2'd0, 2'd1 or 2'd2 once reset has been applied.
- R8: Reset takes priority over a request. A reset edge with `req_i` high still leaves state 2'd0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request bit; high forces the request state |
| lamp_o | output | 2 | Lamp code, a function of the state and `req_i` |
| state_o | output | 2 | Current state code (0, 1 or 2) |

## Verification
A directed walk first visits all six pairs of state and request and checks the lamp code and the next state for each pair. This separates a fault in the output decode from a fault in the next-state table. Within a single cycle, `req_i` is also toggled without a clock edge, which shows whether the lamp output is truly Mealy or has been registered by mistake. A seeded random request sequence with a reset asserted partway through then covers long runs of back-to-back transitions and recovery from reset with a request pending. That part is checked against a reference table kept in the bench.

// File: rtl/tlc_pkg.sv
package tlc_pkg;
    localparam int STATE_W = 2;
    localparam int LAMP_W  = 2;

    typedef logic [STATE_W-1:0] st_code_t;
    typedef logic [LAMP_W-1:0]  lamp_t;

    localparam st_code_t ST_BASE = 2'd0;
    localparam st_code_t ST_ALT  = 2'd1;
    localparam st_code_t ST_REQ  = 2'd2;

    localparam lamp_t LAMP_PHASE_A = 2'b10;
    localparam lamp_t LAMP_PHASE_B = 2'b01;
    localparam lamp_t LAMP_DARK    = 2'b00;

    function automatic logic is_legal(input st_code_t s);
        return (s == ST_BASE) || (s == ST_ALT) || (s == ST_REQ);
    endfunction
endpackage

// File: rtl/tlc_next_state.sv
module tlc_next_state
    import tlc_pkg::*;
(
    input  st_code_t cur_i,
    input  logic     req_i,
    output st_code_t nxt_o
);
    always_comb begin
        if (req_i) begin
            nxt_o = ST_REQ;
        end else begin
            unique case (cur_i)
                ST_BASE: nxt_o = ST_ALT;
                ST_ALT:  nxt_o = ST_BASE;
                ST_REQ:  nxt_o = ST_BASE;
                default: nxt_o = ST_BASE; // unused code recovers
            endcase
        end
    end
endmodule

// File: rtl/tlc_lamp_decode.sv
module tlc_lamp_decode
    import tlc_pkg::*;
(
    input  st_code_t cur_i,
    input  logic     req_i,
    output lamp_t    lamp_o
);
    always_comb begin
        if (req_i) begin
            lamp_o = LAMP_DARK;
        end else begin
            unique case (cur_i)
                ST_BASE: lamp_o = LAMP_PHASE_A;
                ST_ALT:  lamp_o = LAMP_PHASE_B;
                ST_REQ:  lamp_o = LAMP_PHASE_B;
                default: lamp_o = LAMP_DARK; // unused code stays dark
            endcase
        end
    end
endmodule

// File: rtl/tlc_state_reg.sv
module tlc_state_reg
    import tlc_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_i,
    input  st_code_t nxt_i,
    output st_code_t cur_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cur_o <= ST_BASE;
        end else begin
            cur_o <= nxt_i;
        end
    end

    // R1 / R8: a reset edge always lands in the base state
    p_reset_base_r1: assert property (@(posedge clk_i)
        rst_i |=> (cur_o == ST_BASE));

    // R7: only legal codes are held after reset
    p_legal_code_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        is_legal(cur_o));
endmodule

// File: rtl/traffic_mealy_ctrl.sv
module traffic_mealy_ctrl
    import tlc_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              req_i,
    output logic [LAMP_W-1:0] lamp_o,
    output logic [STATE_W-1:0] state_o
);
    st_code_t cur_q;
    st_code_t nxt_d;

    tlc_state_reg u_reg (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .nxt_i (nxt_d),
        .cur_o (cur_q)
    );

    tlc_next_state u_next (
        .cur_i (cur_q),
        .req_i (req_i),
        .nxt_o (nxt_d)
    );

    tlc_lamp_decode u_lamp (
        .cur_i  (cur_q),
        .req_i  (req_i),
        .lamp_o (lamp_o)
    );

    assign state_o = cur_q;

    // R2: base without request steps to alternate
    p_base_step_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_o == ST_BASE && !req_i) |=> (state_o == ST_ALT));

    // R3: alternate without request returns to base
    p_alt_back_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_o == ST_ALT && !req_i) |=> (state_o == ST_BASE));

    // R4: request state without request returns to base
    p_req_back_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_o == ST_REQ && !req_i) |=> (state_o == ST_BASE));

    // R5: a request always leads to the request state with dark lamps
    p_req_jump_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        req_i |=> (state_o == ST_REQ));
    p_req_dark_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        req_i |-> (lamp_o == LAMP_DARK));
endmodule

// File: tb/traffic_mealy_ctrl_tb_top.sv
module traffic_mealy_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int RAND_CYCLES = 300;
    localparam int WATCHDOG = 5000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req = 1'b0;
    logic [1:0] lamp;
    logic [1:0] state;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;
    logic [1:0] model_st = 2'd0;

    always #(CLK_PERIOD/2) clk = ~clk;

    traffic_mealy_ctrl dut_i (
        .clk_i   (clk),
        .rst_i   (rst),
        .req_i   (req),
        .lamp_o  (lamp),
        .state_o (state)
    );

    function automatic logic [1:0] ref_next(input logic [1:0] s, input logic r);
        if (r) return 2'd2;
        case (s)
            2'd0: return 2'd1;
            default: return 2'd0;
        endcase
    endfunction

    function automatic logic [1:0] ref_lamp(input logic [1:0] s, input logic r);
        if (r) return 2'b00;
        case (s)
            2'd0: return 2'b10;
            2'd1: return 2'b01;
            2'd2: return 2'b01;
            default: return 2'b00;
        endcase
    endfunction

    function automatic string tag_for(input logic [1:0] s, input logic r);
        if (r) return "R5";
        case (s)
            2'd0: return "R2";
            2'd1: return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic check(input string req_tag, input logic [1:0] got, input logic [1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req_tag, got, exp);
        end
    endtask

    // one cycle: drive at negedge, check lamp mid-cycle, check state after edge
    task automatic step(input logic r, input logic do_rst);
        @(negedge clk);
        req = r;
        rst = do_rst;
        #1;
        if (!do_rst) check(tag_for(model_st, r), lamp, ref_lamp(model_st, r));
        @(posedge clk);
        #1;
        model_st = do_rst ? 2'd0 : ref_next(model_st, r);
        check(do_rst ? (r ? "R8" : "R1") : tag_for(model_st, r), state, model_st);
        check("R7", {1'b0, (state == 2'd3)}, 2'd0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed_init;
        seed_init = $urandom(32'd2718);
        // R1 / R8: reset with request high
        rst = 1'b1;
        req = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check("R8", state, 2'd0);
        model_st = 2'd0;

        // walk all six state/request pairs
        step(1'b0, 1'b0); // 0 -> 1  R2
        step(1'b0, 1'b0); // 1 -> 0  R3
        step(1'b1, 1'b0); // 0 -> 2  R5
        step(1'b0, 1'b0); // 2 -> 0  R4
        step(1'b0, 1'b0); // 0 -> 1  R2
        step(1'b1, 1'b0); // 1 -> 2  R5
        step(1'b1, 1'b0); // 2 -> 2  R5

        // R6: lamp tracks req without a clock edge
        @(negedge clk);
        req = 1'b0;
        #1;
        check("R6", lamp, 2'b01);
        req = 1'b1;
        #1;
        check("R6", lamp, 2'b00);
        check("R6", state, 2'd2);
        req = 1'b0;
        #1;
        check("R6", lamp, 2'b01);
        @(posedge clk);
        #1;
        model_st = 2'd0;
        check("R4", state, 2'd0);

        // R1: plain reset from state 1
        step(1'b0, 1'b0);
        step(1'b0, 1'b1);

        // seeded random run with a reset partway through
        for (int i = 0; i < RAND_CYCLES; i++) begin
            logic r;
            r = ($urandom % 3) == 0;
            step(r, (i == RAND_CYCLES/2));
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule